// File: doc/BRIEF.md
# Network Controller Interrupt Status Register

This block is the host-visible interrupt status and mask register of a network controller. It latches four kinds of events in sticky status bits. Three of them are hardware events: a wrap of the missed-frame counter, a wrap of the receive-collision counter, and the start of a frame transmission. The fourth is a user interrupt that the host raises through a command bit. Three of the sources have a mask bit, and the user interrupt has none. The block drives one active-low interrupt line. That line is qualified by a global enable and by the OR of every status bit that is not masked.

The host reads and writes the register through a plain 16-bit write/read port, with no handshake. Status bits are write-1-to-clear. Mask bits take the written value. The user command bit is set by writing 1, and the block moves it into the user status bit on the next clock. A hard reset or a soft reset returns the register to its power-up state, which has all masks set. STOP clears every status bit and the command bit, but leaves the masks as they are. The event counters and the frame logic live outside this block.

Top module: `nic_irq_status`

## Requirements
- R1: After hard_rst or soft_rst, rd_data is 16'h002A: every status bit and the command bit are 0, and the three mask bits (1, 3, 5) are 1.
- R2: A one-cycle pulse on src_evt[i] sets status bit 2*i at the next clock edge (i=0 missed-frame wrap, i=1 receive-collision wrap, i=2 transmit start). The bit then stays set until it is cleared.
- R3: Writing 1 to a status bit (0, 2, 4 or 6) clears it. Writing 0 to a status bit leaves it unchanged.
- R4: When a hardware event and a write of 1 to the same status bit arrive in one cycle, the bit ends up set.
- R5: A cycle with stop high clears status bits 0, 2, 4 and 6 and command bit 7. The mask bits keep their values.
- R6: Mask bits 1, 3 and 5 load the value written to them on every write, and they read back that value.
- R7: irq_n is low exactly when irq_en is 1 and at least one of the following holds: a source status bit is set and its mask bit (status position + 1) is 0, or user status bit 6 is set. User status bit 6 cannot be masked. Otherwise irq_n is high.
- R8: Writing 1 to bit 7 makes bit 7 read 1 after that clock edge. At the next edge, bit 6 reads 1 and bit 7 reads 0. Writing 0 to bit 7 has no effect.
- R9: Bits 15:8 always read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| hard_rst | input | 1 | Synchronous hard reset, active high |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| stop | input | 1 | STOP control, clears status and command when high |
| irq_en | input | 1 | Global interrupt enable |
| src_evt | input | 3 | Event pulses: missed wrap, collision wrap, transmit start |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 16 | Host write data |
| rd_data | output | 16 | Current register value |
| irq_n | output | 1 | Interrupt line, active low |

## Verification
The assertions assume the following about the inputs: event inputs are single-cycle pulses, and a write does not coincide with stop when the masks are being checked for stability. The stimulus holds every input steady between falling edges, and it issues events, writes and STOP in separate cycles, except in the one test that deliberately overlaps an event with a clear. The bench sweeps every source against both mask values and both enable values. For each combination it computes the expected register word and the expected line level arithmetically.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int REG_W   = 16;
  localparam int NUM_SRC = 3;
  localparam int USR_ST  = 2 * NUM_SRC;
  localparam int USR_CMD = USR_ST + 1;
  localparam int USED_W  = USR_CMD + 1;

  function automatic int st_pos(input int i);
    return 2 * i;
  endfunction

  function automatic int mk_pos(input int i);
    return 2 * i + 1;
  endfunction
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk,
  input  logic rst,
  input  logic stop,
  input  logic evt,
  input  logic wr_en,
  input  logic wr_st,
  input  logic wr_mk,
  output logic st,
  output logic mk
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st <= 1'b0;
      mk <= 1'b1;
    end else begin
      if (stop)
        st <= 1'b0;
      else if (evt)
        st <= 1'b1;
      else if (wr_en && wr_st)
        st <= 1'b0;
      if (wr_en)
        mk <= wr_mk;
    end
  end
endmodule

// File: rtl/user_irq_cell.sv
module user_irq_cell (
  input  logic clk,
  input  logic rst,
  input  logic stop,
  input  logic wr_en,
  input  logic wr_cmd,
  input  logic wr_st,
  output logic cmd,
  output logic st
);
  always_ff @(posedge clk) begin
    if (rst || stop) begin
      cmd <= 1'b0;
      st  <= 1'b0;
    end else begin
      cmd <= wr_en && wr_cmd;
      if (cmd)
        st <= 1'b1;
      else if (wr_en && wr_st)
        st <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
  parameter int NSRC = 3
) (
  input  logic [NSRC-1:0] st,
  input  logic [NSRC-1:0] mk,
  input  logic            usr_st,
  input  logic            irq_en,
  output logic            irq_n
);
  logic pending;
  always_comb begin
    pending = usr_st;
    for (int i = 0; i < NSRC; i++)
      pending = pending | (st[i] & ~mk[i]);
    irq_n = ~(irq_en & pending);
  end
endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status
  import nic_irq_pkg::*;
(
  input  logic             clk,
  input  logic             hard_rst,
  input  logic             soft_rst,
  input  logic             stop,
  input  logic             irq_en,
  input  logic [2:0]       src_evt,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             irq_n
);
  logic               rst;
  logic [NUM_SRC-1:0] st_v;
  logic [NUM_SRC-1:0] mk_v;
  logic               usr_cmd;
  logic               usr_st;
  logic               unused_hi;

  assign rst       = hard_rst | soft_rst;
  assign unused_hi = ^wr_data[REG_W-1:USED_W];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irq_src_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .stop  (stop),
      .evt   (src_evt[g]),
      .wr_en (wr_en),
      .wr_st (wr_data[st_pos(g)]),
      .wr_mk (wr_data[mk_pos(g)]),
      .st    (st_v[g]),
      .mk    (mk_v[g])
    );
  end

  user_irq_cell u_user (
    .clk    (clk),
    .rst    (rst),
    .stop   (stop),
    .wr_en  (wr_en),
    .wr_cmd (wr_data[USR_CMD]),
    .wr_st  (wr_data[USR_ST]),
    .cmd    (usr_cmd),
    .st     (usr_st)
  );

  irq_summary #(.NSRC(NUM_SRC)) u_sum (
    .st     (st_v),
    .mk     (mk_v),
    .usr_st (usr_st),
    .irq_en (irq_en),
    .irq_n  (irq_n)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      rd_data[st_pos(i)] = st_v[i];
      rd_data[mk_pos(i)] = mk_v[i];
    end
    rd_data[USR_ST]  = usr_st;
    rd_data[USR_CMD] = usr_cmd;
  end
endmodule

// File: rtl/nic_irq_status_chk.sv
module nic_irq_status_chk (
  input logic        clk,
  input logic        hard_rst,
  input logic        soft_rst,
  input logic        stop,
  input logic        irq_en,
  input logic [2:0]  src_evt,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        irq_n
);
  logic rst;
  assign rst = hard_rst | soft_rst;

  assert_reset_value_R1: assert property (@(posedge clk)
    hard_rst |=> rd_data == 16'h002A);

  assert_tx_event_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (src_evt[2] && !stop) |=> rd_data[4]);

  assert_set_beats_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (src_evt[0] && !stop && wr_en && wr_data[0]) |=> rd_data[0]);

  assert_stop_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (stop && !wr_en) |=> (rd_data[7:6] == 2'b00 && rd_data[4] == 1'b0 &&
                          rd_data[2] == 1'b0 && rd_data[0] == 1'b0 &&
                          $stable({rd_data[5], rd_data[3], rd_data[1]})));

  assert_disabled_line_high_R7: assert property (@(posedge clk) disable iff (rst)
    !irq_en |-> irq_n);

  assert_user_unmaskable_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_en && rd_data[6]) |-> !irq_n);

  assert_cmd_transfer_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_data[7] && !stop && !(wr_en && wr_data[7])) |=> (rd_data[6] && !rd_data[7]));

  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
    rd_data[15:8] == 8'h00);
endmodule

bind nic_irq_status nic_irq_status_chk chk_i (
  .clk      (clk),
  .hard_rst (hard_rst),
  .soft_rst (soft_rst),
  .stop     (stop),
  .irq_en   (irq_en),
  .src_evt  (src_evt),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .irq_n    (irq_n)
);

// File: tb/nic_irq_status_tb_top.sv
module nic_irq_status_tb_top;
  logic        clk = 1'b0;
  logic        hard_rst, soft_rst, stop, irq_en, wr_en;
  logic [2:0]  src_evt;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        irq_n;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  nic_irq_status dut_i (
    .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst), .stop(stop),
    .irq_en(irq_en), .src_evt(src_evt), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    hard_rst = 0; soft_rst = 0; stop = 0; wr_en = 0; src_evt = 0; wr_data = 0;
  endtask

  task automatic host_wr(input logic [15:0] d);
    wr_en = 1; wr_data = d;
    step();
  endtask

  initial begin
    hard_rst = 1; soft_rst = 0; stop = 0; irq_en = 0; wr_en = 0;
    src_evt = 0; wr_data = 0;
    @(negedge clk);
    step();
    chk("R1 hard reset value", rd_data, 16'h002A);
    chk("R7 idle line", {15'd0, irq_n}, 16'd1);

    // R2 R6 R7 sweep: each source, each mask value, each enable value
    for (int s = 0; s < 3; s++) begin
      for (int mv = 0; mv < 2; mv++) begin
        for (int en = 0; en < 2; en++) begin
          logic [15:0] masks;
          soft_rst = 1; step();
          masks = 16'h002A & ~(16'(1 - mv) << (2 * s + 1));
          host_wr(masks);
          chk("R6 mask readback", rd_data, masks);
          irq_en = en[0];
          src_evt = 3'(1 << s); step();
          chk("R2 status set", rd_data, masks | (16'd1 << (2 * s)));
          chk("R7 line level", {15'd0, irq_n}, {15'd0, ~(en[0] & (mv == 0))});
        end
      end
    end

    // R3: W0 no effect, W1 clears
    soft_rst = 1; step();
    irq_en = 1;
    host_wr(16'h0000);
    src_evt = 3'b011; step();
    chk("R3 two sources set", rd_data, 16'h0005);
    host_wr(16'h0000);
    chk("R3 write zero keeps", rd_data, 16'h0005);
    host_wr(16'h0001);
    chk("R3 write one clears", rd_data, 16'h0004);
    chk("R7 remaining unmasked", {15'd0, irq_n}, 16'd0);
    host_wr(16'h0004);
    chk("R7 line released", {15'd0, irq_n}, 16'd1);

    // R4: event and clear together
    src_evt = 3'b100; wr_en = 1; wr_data = 16'h0010; step();
    chk("R4 set wins", rd_data, 16'h0010);

    // R5: stop clears status, keeps masks
    host_wr(16'h0028);
    src_evt = 3'b111; step();
    chk("R5 before stop", rd_data, 16'h003D);
    stop = 1; step();
    chk("R5 after stop", rd_data, 16'h0028);

    // R8: command transfer
    wr_en = 1; wr_data = 16'h00A8; @(posedge clk); @(negedge clk);
    wr_en = 0; wr_data = 0;
    chk("R8 cmd visible", rd_data, 16'h00A8);
    step();
    chk("R8 status latched, cmd cleared", rd_data, 16'h0068);
    chk("R7 user unmaskable", {15'd0, irq_n}, 16'd0);
    host_wr(16'h0028);
    chk("R8 write zero cmd no effect", rd_data, 16'h0068);
    host_wr(16'h0068);
    chk("R3 user status cleared", rd_data, 16'h0028);
    wr_en = 1; wr_data = 16'h00A8; @(posedge clk); @(negedge clk);
    wr_en = 0; wr_data = 0; stop = 1; step();
    chk("R5 stop clears cmd", rd_data, 16'h0028);

    // R9: upper bits
    host_wr(16'hFF2A);
    chk("R9 upper bits zero", rd_data, 16'h002A);

    // R1: hard reset from a busy state
    host_wr(16'h0000);
    src_evt = 3'b111; step();
    hard_rst = 1; step();
    chk("R1 hard reset after activity", rd_data, 16'h002A);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule